// File: doc/BRIEF.md
# Floppy Drive Ready Emulator

This block produces an active-low drive-ready line for floppy drives that cannot supply one themselves. It watches the active-low motor-on and index-pulse lines. Ready is claimed only after the spindle has shown index pulses while the motor runs. A retriggerable countdown keeps ready asserted between pulses and drops it when the pulses stop, for example when the medium is ejected with the motor still spinning. Switching the motor off drops ready immediately.

A mode input works like a board jumper. It chooses between the emulated ready and the drive's own ready pin, which is then passed straight through. The block also combines the two drive-select lines with a head-selection switch for each drive, giving one active-low head-select output. The timeout is counted in clock cycles. Its default is one fifth of the clock frequency parameter, which is 200 ms.

Top module: `fdd_ready_emu`

## Requirements
- R1: After reset, with the mode input `emulate`=1, `ready_n` is 1 (inactive).
- R2: Switching the motor on (`motor_n`=0) does not by itself assert `ready_n`. The line stays 1 indefinitely without index pulses.
- R3: An index falling edge seen while `motor_n`=1 has no effect. `ready_n` stays 1 after the motor is later switched on.
- R4: A falling edge on `index_n` while `motor_n`=0 drives `ready_n` to 0 on the third rising clock edge after the edge is applied. The delay comes from two synchroniser stages and one timer register.
- R5: Each qualifying index edge reloads the timer to TIMEOUT_CYCLES. Pulses spaced less than TIMEOUT_CYCLES apart keep `ready_n` at 0 without a gap.
- R6: With no further index edge, `ready_n` returns to 1 exactly TIMEOUT_CYCLES clock cycles after it went to 0. This is the eject case.
- R7: `motor_n` going to 1 forces `ready_n` to 1 in the same cycle, without waiting for a clock edge.
- R8: One index pulse reloads the timer only once, whatever its width. A low level held longer than the timeout does not keep ready asserted.
- R9: With MIN_INDEX=2, ready first asserts on the second qualifying index edge, not the first. The count of edges seen is kept no higher than MIN_INDEX.
- R10: With GATE_SELECT=1, the emulated `ready_n` is 1 while both `sel0_n` and `sel1_n` are 1. With GATE_SELECT=0, the drive selects do not affect it.
- R11: With `emulate`=0, `ready_n` equals `drive_ready_n` in the same cycle.
- R12: `head_n` is 0 exactly when (`sel0_n`=0 and `hsw0_n`=0) or (`sel1_n`=0 and `hsw1_n`=0). Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| emulate | input | 1 | 1 = emulated ready, 0 = pass through the drive's ready |
| motor_n | input | 1 | Motor on, active low |
| index_n | input | 1 | Index pulse from the drive, active low, asynchronous |
| sel0_n | input | 1 | Drive 0 select, active low |
| sel1_n | input | 1 | Drive 1 select, active low |
| hsw0_n | input | 1 | Head switch for drive 0, active low |
| hsw1_n | input | 1 | Head switch for drive 1, active low |
| drive_ready_n | input | 1 | The drive's own ready line, active low |
| ready_n | output | 1 | Ready to the controller, active low |
| head_n | output | 1 | Head select to the drive, active low |

## Verification
A timer that reloads to the wrong value or decrements wrongly shows up as a shifted deassertion cycle in the expiry case. That error becomes visible TIMEOUT_CYCLES cycles after the last pulse. A broken edge detector shows in the wide-pulse case, where ready must drop while index is still low. A stale pulse count shows as early assertion on the first pulse in the two-pulse configuration, within three cycles of that pulse. A missing motor gate shows as ready held for one cycle after the motor is switched off.

// File: rtl/fdd_ready_emu.sv
module fdd_ready_emu #(
  parameter int CLK_HZ         = 50_000_000,
  parameter int TIMEOUT_CYCLES = CLK_HZ / 5,
  parameter int MIN_INDEX      = 1,
  parameter bit GATE_SELECT    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic emulate,
  input  logic motor_n,
  input  logic index_n,
  input  logic sel0_n,
  input  logic sel1_n,
  input  logic hsw0_n,
  input  logic hsw1_n,
  input  logic drive_ready_n,
  output logic ready_n,
  output logic head_n
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int PW = $clog2(MIN_INDEX + 1);
  localparam logic [CW-1:0] TMAX = CW'(TIMEOUT_CYCLES);
  localparam logic [PW-1:0] PMIN = PW'(MIN_INDEX);

  logic [1:0]    idx_sync;
  logic          idx_prev;
  logic [CW-1:0] cnt;
  logic [PW-1:0] seen;

  wire motor_on = ~motor_n;
  wire idx_fall = idx_prev & ~idx_sync[1];
  wire qual     = idx_fall & motor_on;
  wire expiring = (cnt == CW'(1)) & ~qual;
  wire armed    = (cnt != '0) & (seen >= PMIN);
  wire selected = ~sel0_n | ~sel1_n;
  wire emu_rdy  = armed & motor_on & (GATE_SELECT ? selected : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_sync <= 2'b11;
      idx_prev <= 1'b1;
    end else begin
      idx_sync <= {idx_sync[0], index_n};
      idx_prev <= idx_sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!motor_on)  cnt <= '0;
    else if (qual)       cnt <= TMAX;
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      seen <= '0;
    else if (!motor_on || expiring)  seen <= '0;
    else if (qual && seen < PMIN)    seen <= seen + PW'(1);
  end

  assign ready_n = emulate ? ~emu_rdy : drive_ready_n;
  assign head_n  = ~((~sel0_n & ~hsw0_n) | (~sel1_n & ~hsw1_n));

  // R3
  motor_off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    motor_n |=> (cnt == '0) && (seen == '0));
  // R4
  arm_needs_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(qual));
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> cnt == TMAX);
  // R6
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (motor_on && !qual && cnt != '0) |=> cnt == $past(cnt) - CW'(1));
  // R9
  seen_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen <= PMIN);
endmodule

// File: tb/fdd_ready_emu_tb.sv
module fdd_ready_emu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic emulate = 1'b1, motor_n = 1'b1, index_n = 1'b1;
  logic sel0_n = 1'b0, sel1_n = 1'b1, hsw0_n = 1'b1, hsw1_n = 1'b1;
  logic drive_ready_n = 1'b1;
  logic ready_n, head_n, ready2_n, head2_n;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdd_ready_emu #(.CLK_HZ(100), .TIMEOUT_CYCLES(T), .MIN_INDEX(1), .GATE_SELECT(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .emulate(emulate), .motor_n(motor_n), .index_n(index_n),
    .sel0_n(sel0_n), .sel1_n(sel1_n), .hsw0_n(hsw0_n), .hsw1_n(hsw1_n),
    .drive_ready_n(drive_ready_n), .ready_n(ready_n), .head_n(head_n));

  fdd_ready_emu #(.CLK_HZ(100), .TIMEOUT_CYCLES(T), .MIN_INDEX(2), .GATE_SELECT(1'b1)) dut_g_i (
    .clk(clk), .rst_n(rst_n), .emulate(emulate), .motor_n(motor_n), .index_n(index_n),
    .sel0_n(sel0_n), .sel1_n(sel1_n), .hsw0_n(hsw0_n), .hsw1_n(hsw1_n),
    .drive_ready_n(drive_ready_n), .ready_n(ready2_n), .head_n(head2_n));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_motor_off();
    motor_n = 1'b1; index_n = 1'b1;
    step(5);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1", ready_n, 1'b1);
    chk("R1", ready2_n, 1'b1);

    motor_n = 1'b0;
    for (int i = 0; i < 50; i++) begin step(1); chk("R2", ready_n, 1'b1); end

    idle_motor_off();
    index_n = 1'b0; step(4); index_n = 1'b1; step(4);
    motor_n = 1'b0;
    for (int i = 0; i < 30; i++) begin step(1); chk("R3", ready_n, 1'b1); end

    idle_motor_off();
    motor_n = 1'b0; step(2);
    index_n = 1'b0;
    step(2); chk("R4 before", ready_n, 1'b1);
    index_n = 1'b1;
    step(1); chk("R4 assert", ready_n, 1'b0);
    step(T - 1); chk("R6 last low", ready_n, 1'b0);
    step(1); chk("R6 expire", ready_n, 1'b1);

    idle_motor_off();
    motor_n = 1'b0; step(2);
    for (int i = 0; i < 90; i++) begin
      index_n = ((i % 15) < 4) ? 1'b0 : 1'b1;
      if (i >= 3) chk("R5 continuous", ready_n, 1'b0);
      step(1);
    end
    index_n = 1'b1;
    motor_n = 1'b1; #1;
    chk("R7 same cycle", ready_n, 1'b1);
    step(1); chk("R7 held", ready_n, 1'b1);

    idle_motor_off();
    motor_n = 1'b0; step(2);
    index_n = 1'b0;
    step(3); chk("R8 assert", ready_n, 1'b0);
    step(T - 1); chk("R8 last low", ready_n, 1'b0);
    step(1); chk("R8 expire while index low", ready_n, 1'b1);
    step(10); chk("R8 no retrigger", ready_n, 1'b1);
    index_n = 1'b1;

    idle_motor_off();
    motor_n = 1'b0; sel0_n = 1'b0; step(2);
    index_n = 1'b0; step(2); index_n = 1'b1; step(1);
    chk("R9 one pulse min1", ready_n, 1'b0);
    chk("R9 one pulse min2", ready2_n, 1'b1);
    step(7);
    index_n = 1'b0; step(2); index_n = 1'b1; step(1);
    chk("R9 two pulses min2", ready2_n, 1'b0);
    sel0_n = 1'b1; sel1_n = 1'b1; #1;
    chk("R10 deselected gated", ready2_n, 1'b1);
    chk("R10 ungated", ready_n, 1'b0);
    sel1_n = 1'b0; #1;
    chk("R10 drive1 selected", ready2_n, 1'b0);
    sel0_n = 1'b0; sel1_n = 1'b1;

    emulate = 1'b0;
    for (int v = 0; v < 2; v++) begin
      drive_ready_n = v[0]; #1;
      chk("R11 bypass", ready_n, v[0]);
      chk("R11 bypass g", ready2_n, v[0]);
    end
    emulate = 1'b1;

    for (int v = 0; v < 16; v++) begin
      {sel0_n, hsw0_n, sel1_n, hsw1_n} = 4'(v); #1;
      chk("R12 head", head_n, ~((~v[3] & ~v[2]) | (~v[1] & ~v[0])));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule